// File: doc/BRIEF.md
# Pipelined Counted-Loop Engine

This block executes a fixed counted loop as a three-stage hardware pipeline that accepts one new iteration every clock cycle. A loop-control unit owns the induction variable. It evaluates the continue test and the increment separately from the datapath, and it hands the current index to the first stage. Stage 0 issues a read of the source memory at that index. Stage 1 adds a constant to the returned word. Stage 2 writes the sum into the destination memory.

The index travels down the stage registers together with a valid bit and the data. Each stage therefore works with the index of its own iteration, and the write address is the carried index, not the current counter value. A single start pulse runs the whole loop: ten iterations with indices 0 through 9. A one-cycle done pulse marks the end of the drain. The source memory is external, with a synchronous read of one cycle latency. The destination memory is external, with a simple write strobe.

Top module: `pipelined_loop_engine`

## Requirements
- R1: While reset is high, and while idle after reset with no start, rd_en, wr_en and done are all low.
- R2: When start is sampled high while idle, rd_en is high for ten consecutive cycles, beginning in the cycle after that edge, with rd_addr equal to 0, 1, 2, ... 9 in that order.
- R3: No read is issued for an index of 10 or more, so exactly ten reads occur per run.
- R4: Each write carries the source word returned one cycle after its read, plus 1, modulo 2^32 (0xFFFFFFFF becomes 0x00000000).
- R5: Each write occurs exactly two cycles after the read of the same iteration, and wr_addr equals that read's rd_addr.
- R6: wr_en is high for exactly ten consecutive cycles per run, and no destination address of 10 or more is written.
- R7: done is high for exactly one cycle, the cycle after the last write, which is 13 cycles after the edge that accepted start. It is never high at the same time as rd_en or wr_en.
- R8: start is ignored while a run is in progress, including the done cycle. A start pulse in that window neither restarts the index nor adds reads, writes or done pulses.
- R9: A start accepted after done begins a fresh run whose first read address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop run when idle |
| done | output | 1 | One-cycle pulse when the pipeline has drained |
| rd_en | output | 1 | Source memory read request (stage 0) |
| rd_addr | output | 4 | Source memory read index |
| rd_data | input | 32 | Source memory data, valid one cycle after rd_en |
| wr_en | output | 1 | Destination memory write strobe (stage 2) |
| wr_addr | output | 4 | Destination write index, carried from stage 0 |
| wr_data | output | 32 | Destination write data |

## Verification
In steady state, three iterations are in flight at once. In every cycle from the third to the tenth of a run, the read of iteration i+2 and the write of iteration i share a cycle, with different addresses on the two ports. The bench logs every read and write with its cycle number and checks each write's cycle, address and data against the read log of the same run. A wrong index carried into stage 2 would then show up as a write address that matches the read issued in the same cycle instead of the read two cycles earlier. A second overlap is provoked by raising start in the middle of a run and again in the done cycle; the read, write and done counts must stay unchanged.

// File: rtl/plp_pkg.sv
package plp_pkg;

    localparam int DATA_W     = 32;
    localparam int LOOP_BEGIN = 0;
    localparam int LOOP_END   = 10;
    localparam int LOOP_STEP  = 1;
    localparam int ADD_K      = 1;
    localparam int IDX_W      = $clog2(LOOP_END + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // token leaving stage 0: the iteration tag only
    typedef struct packed {
        logic live;
        idx_t idx;
    } tag_t;

    // token leaving stage 1: tag plus computed word
    typedef struct packed {
        logic  live;
        idx_t  idx;
        word_t sum;
    } beat_t;

    typedef enum logic {LC_IDLE, LC_RUN} lc_state_e;

    function automatic logic keep_going(idx_t i);
        return i < idx_t'(LOOP_END);
    endfunction

    function automatic idx_t step_idx(idx_t i);
        return i + idx_t'(LOOP_STEP);
    endfunction

    function automatic word_t add_const(word_t w);
        return w + word_t'(ADD_K);
    endfunction

endpackage

// File: rtl/plp_loop_ctrl.sv
module plp_loop_ctrl
    import plp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic drain_empty,
    output logic issue,
    output idx_t cur_idx,
    output logic fin
);
    lc_state_e state_q;
    idx_t      idx_q;
    logic      cont;

    assign cont    = keep_going(idx_q);
    assign issue   = (state_q == LC_RUN) && cont;
    assign fin     = (state_q == LC_RUN) && !cont && drain_empty;
    assign cur_idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LC_IDLE;
            idx_q   <= idx_t'(LOOP_BEGIN);
        end else begin
            case (state_q)
                LC_IDLE: begin
                    if (start) begin
                        state_q <= LC_RUN;
                        idx_q   <= idx_t'(LOOP_BEGIN);
                    end
                end
                LC_RUN: begin
                    if (issue) idx_q <= step_idx(idx_q);
                    if (fin)   state_q <= LC_IDLE;
                end
                default: state_q <= LC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/plp_fetch_stage.sv
module plp_fetch_stage
    import plp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  idx_t idx,
    output tag_t s1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.live <= issue;
            if (issue) s1.idx <= idx;
        end
    end
endmodule

// File: rtl/plp_add_stage.sv
module plp_add_stage
    import plp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tag_t  s1,
    input  word_t rdata,
    output beat_t s2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.live <= s1.live;
            if (s1.live) begin
                s2.idx <= s1.idx;
                s2.sum <= add_const(rdata);
            end
        end
    end
endmodule

// File: rtl/pipelined_loop_engine.sv
module pipelined_loop_engine
    import plp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic  issue;
    idx_t  cur_idx;
    logic  fin;
    tag_t  s1;
    beat_t s2;
    logic  drain_empty;

    assign drain_empty = !s1.live && !s2.live;

    plp_loop_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .drain_empty (drain_empty),
        .issue       (issue),
        .cur_idx     (cur_idx),
        .fin         (fin)
    );

    plp_fetch_stage u_st0 (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .idx   (cur_idx),
        .s1    (s1)
    );

    plp_add_stage u_st1 (
        .clk   (clk),
        .rst   (rst),
        .s1    (s1),
        .rdata (rd_data),
        .s2    (s2)
    );

    assign rd_en   = issue;
    assign rd_addr = cur_idx;
    assign wr_en   = s2.live;
    assign wr_addr = s2.idx;
    assign wr_data = s2.sum;
    assign done    = fin;

endmodule

// File: rtl/plp_chk.sv
module plp_chk
    import plp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    // R2
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr != '0) |-> ($past(rd_en) && rd_addr == idx_t'($past(rd_addr) + 1)));

    // R3
    read_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr < idx_t'(LOOP_END)));

    // R4
    sum_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data == $past(rd_data) + word_t'(ADD_K)));

    // R5
    carried_index_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(rd_en, 2) && wr_addr == $past(rd_addr, 2)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_en && !wr_en));
endmodule

bind pipelined_loop_engine plp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/tb_pipelined_loop_engine.sv
`timescale 1ns/1ps
module tb_pipelined_loop_engine;
    import plp_pkg::*;

    localparam int DEPTH = 2 ** IDX_W;
    localparam int NIT   = LOOP_END;
    localparam word_t SENT = 32'hDEAD_BEEF;

    localparam word_t VEC_SRC [NIT] = '{
        32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234_5678,
        32'hFFFF_FFFE, 32'h8000_0000, 32'h0000_FFFF, 32'hA5A5_A5A5, 32'h0FFF_FFFF};
    localparam word_t VEC_EXP [NIT] = '{
        32'h0000_0001, 32'h0000_0002, 32'h0000_0000, 32'h8000_0000, 32'h1234_5679,
        32'hFFFF_FFFF, 32'h8000_0001, 32'h0001_0000, 32'hA5A5_A5A6, 32'h1000_0000};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic done, rd_en, wr_en;
    idx_t rd_addr, wr_addr;
    word_t rd_data, wr_data;

    always #2.5 clk = ~clk;

    pipelined_loop_engine dut (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    word_t src [DEPTH];
    word_t dst [DEPTH];
    word_t expv [NIT];

    always @(posedge clk) if (rd_en) rd_data <= src[rd_addr];
    always @(posedge clk) if (wr_en) dst[wr_addr] <= wr_data;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_rd = 0, n_wr = 0, n_dn = 0;
    int rd_cyc [64]; idx_t rd_adr [64];
    int wr_cyc [64]; idx_t wr_adr [64];
    int dn_cyc [64];

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_en && n_rd < 64) begin rd_cyc[n_rd] = cyc; rd_adr[n_rd] = rd_addr; n_rd++; end
            if (wr_en && n_wr < 64) begin wr_cyc[n_wr] = cyc; wr_adr[n_wr] = wr_addr; n_wr++; end
            if (done && n_dn < 64) begin dn_cyc[n_dn] = cyc; n_dn++; end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // poke1/poke2: cycle offsets after the accepting edge at which start is re-raised (0 = none)
    task automatic run_loop(input string name, input int poke1, input int poke2);
        int b_rd, b_wr, b_dn, k;
        for (int i = 0; i < DEPTH; i++) dst[i] = SENT;
        b_rd = n_rd; b_wr = n_wr; b_dn = n_dn;
        @(negedge clk);
        k = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cyc < k + 22) begin
            if ((poke1 != 0 && cyc == k + poke1) || (poke2 != 0 && cyc == k + poke2)) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        // R3 exactly ten reads
        chk(n_rd - b_rd == NIT, "R3", {name, " read count"}, n_rd - b_rd, NIT);
        // R2 read cycles and ascending addresses
        for (int i = 0; i < NIT; i++) begin
            chk(rd_cyc[b_rd+i] == k + 1 + i, "R2", {name, " read cycle"}, rd_cyc[b_rd+i], k + 1 + i);
            chk(rd_adr[b_rd+i] == idx_t'(i), "R2", {name, " read addr"}, rd_adr[b_rd+i], i);
        end
        // R9 fresh start at index 0
        chk(rd_adr[b_rd] == '0, "R9", {name, " first read addr"}, rd_adr[b_rd], 0);
        // R6 ten writes
        chk(n_wr - b_wr == NIT, "R6", {name, " write count"}, n_wr - b_wr, NIT);
        for (int i = 0; i < NIT; i++) begin
            // R5 write two cycles after matching read, same index
            chk(wr_cyc[b_wr+i] == rd_cyc[b_rd+i] + 2, "R5", {name, " write cycle"}, wr_cyc[b_wr+i], rd_cyc[b_rd+i] + 2);
            chk(wr_adr[b_wr+i] == rd_adr[b_rd+i], "R5", {name, " write addr"}, wr_adr[b_wr+i], rd_adr[b_rd+i]);
            // R4 data plus one, wrapping
            chk(dst[i] == expv[i], "R4", {name, " dest word"}, dst[i], expv[i]);
        end
        // R6 untouched beyond the loop range
        for (int i = NIT; i < DEPTH; i++)
            chk(dst[i] == SENT, "R6", {name, " dest beyond range"}, dst[i], SENT);
        // R7 single done pulse, cycle after last write
        chk(n_dn - b_dn == 1, "R7", {name, " done count"}, n_dn - b_dn, 1);
        chk(dn_cyc[b_dn] == k + 13, "R7", {name, " done cycle"}, dn_cyc[b_dn], k + 13);
        chk(dn_cyc[b_dn] == wr_cyc[b_wr+NIT-1] + 1, "R7", {name, " done after last write"},
            dn_cyc[b_dn], wr_cyc[b_wr+NIT-1] + 1);
        if (poke1 != 0 || poke2 != 0) begin
            // R8 start during busy or done cycle leaves the run unchanged
            chk(n_rd - b_rd == NIT && n_dn - b_dn == 1, "R8", {name, " pokes ignored"},
                n_rd - b_rd, NIT);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) src[i] = '0;
        // R1 outputs quiet in reset
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R1", "in reset", {rd_en, wr_en, done}, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(n_rd == 0 && n_wr == 0 && n_dn == 0, "R1", "idle without start", n_rd + n_wr + n_dn, 0);

        // table walk
        for (int i = 0; i < NIT; i++) begin src[i] = VEC_SRC[i]; expv[i] = VEC_EXP[i]; end
        run_loop("table", 0, 0);

        // computed pattern, start pokes mid-run (offset 5) and in the done cycle (offset 13)
        for (int i = 0; i < NIT; i++) begin
            src[i]  = word_t'(i) * 32'h1357_9BDF + 32'hF000_0000;
            expv[i] = src[i] + 32'd1;
        end
        run_loop("poked", 5, 13);

        // back-to-back rerun straight after the poked run's idle return
        for (int i = 0; i < NIT; i++) begin src[i] = ~word_t'(i); expv[i] = ~word_t'(i) + 32'd1; end
        run_loop("rerun", 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule